// File: doc/BRIEF.md
# Four-Key Code Sequence Detector

This block watches four push-key lines, each standing for one symbol from 0 to 3. It recognises the code 1,2,3,0,0,3,2,1 when the keys are pressed in that order. The whole block runs from a free-running system clock (nominally 32 MHz), so every raw key line is first brought into the clock domain. Each physical press is then reduced to a single one-cycle event taken on the released-to-pressed transition. Holding a key down produces nothing more. A repeated symbol such as the two 0 presses therefore needs the key to be let go between them.

A tracker holds the number of symbols matched so far. It moves only on a press event. When all eight symbols have been entered, a registered unlock flag goes high. The flag stays high until reset or until the next press, and that next press is taken as the first symbol of a fresh attempt. The match count is brought out as a port, so the progress of an entry can be observed directly.

Top module: `code_lock_top`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released, progress is 0 and unlock is 0. Asserting reset in the middle of an entry, or after a successful entry, clears both.
- R2: Pressing single keys in the order 1,2,3,0,0,3,2,1 brings progress to 8 and drives unlock to 1. Unlock is 1 exactly when progress is 8.
- R3: A key line is high while its key is pressed, and line i carries symbol i. A correct press raises progress by one. The change becomes visible on the third rising clock edge after the raw line goes high, and not before.
- R4: A key held down for any number of cycles gives exactly one event. Two presses of the same key, with a release between them, count as two symbols.
- R5: If no key makes a released-to-pressed transition, progress and unlock do not change. This includes key releases and keys that are held down.
- R6: A single press of a key other than the expected one sets progress to 0. If that wrong key is 1, progress is set to 1 instead.
- R7: If two or more keys show a new press in the same cycle, the entry counts as wrong and progress returns to 0.
- R8: Once unlock is 1, the next press clears it and begins a new attempt. That press sets progress to 1 if it is key 1, and to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_raw | input | 4 | Raw key lines, bit i high while key i is pressed |
| unlock | output | 1 | High once the full code has been entered |
| progress | output | 4 | Number of code symbols matched so far (0 to 8) |

## Verification
The hardest situation to reach from the ports is two new presses landing in exactly the same synchronised cycle. The bench reaches it by raising two key lines on the same falling edge, so that both pass through identical synchroniser delays. Before this, it builds up progress with a partial entry, so that a return to 0 can be seen. The bench also holds a key for many cycles and then releases it, to show that neither the hold nor the release is counted. It times a press against the clock edges so that the three-edge latency is checked exactly.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
    localparam int KEYS    = 4;
    localparam int SYM_W   = $clog2(KEYS);
    localparam int SEQ_LEN = 8;
    localparam int CNT_W   = $clog2(SEQ_LEN + 1);
    // symbol k of the code sits at bits [k*SYM_W +: SYM_W]
    localparam logic [SEQ_LEN*SYM_W-1:0] CODE =
        {2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1};
endpackage

// File: rtl/key_sync.sv
module key_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] press
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw;
        for (int k = 1; k < STAGES; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one event per line on the released-to-pressed step
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign press[i] = st_q.pipe[STAGES-1][i] & ~st_q.prev[i];
    end

    // R4: a line that fired cannot fire again on the next cycle
    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (press != '0) |=> ((press & $past(press)) == '0));
endmodule

// File: rtl/press_encode.sv
module press_encode #(
    parameter int N     = 4,
    parameter int SYM_W = 2
) (
    input  logic [N-1:0]     press,
    output logic             any_o,
    output logic             multi_o,
    output logic [SYM_W-1:0] sym_o
);
    always_comb begin
        any_o   = |press;
        multi_o = ($countones(press) > 1);
        sym_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (press[i]) sym_o = i[SYM_W-1:0];
        end
    end
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker #(
    parameter int SYM_W   = 2,
    parameter int SEQ_LEN = 8,
    parameter int CNT_W   = 4,
    parameter logic [SEQ_LEN*SYM_W-1:0] CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             multi,
    input  logic [SYM_W-1:0] sym,
    output logic [CNT_W-1:0] progress,
    output logic             match
);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(SEQ_LEN);
    localparam logic [SYM_W-1:0] FIRST = CODE[SYM_W-1:0];

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hit;
    } trk_t;

    trk_t st_d, st_q;
    int unsigned      base;
    logic [SYM_W-1:0] want;

    always_comb begin
        st_d = st_q;
        // a finished entry restarts from the first symbol
        base = (st_q.cnt == FULL) ? 0 : int'(st_q.cnt);
        want = CODE[base*SYM_W +: SYM_W];
        if (evt) begin
            if (multi)             st_d.cnt = '0;
            else if (sym == want)  st_d.cnt = CNT_W'(base + 1);
            else if (sym == FIRST) st_d.cnt = CNT_W'(1);
            else                   st_d.cnt = '0;
        end
        st_d.hit = (st_d.cnt == FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign progress = st_q.cnt;
    assign match    = st_q.hit;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> ($stable(progress) && $stable(match)));
    p_multi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && multi) |=> (progress == '0));
    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        progress <= FULL);
    p_unlock_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match) |-> ($past(evt) && progress == FULL));
    p_unlock_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && evt) |=> !match);
endmodule

// File: rtl/code_lock_top.sv
module code_lock_top
    import code_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEYS-1:0]  key_raw,
    output logic             unlock,
    output logic [CNT_W-1:0] progress
);
    logic [KEYS-1:0]  press;
    logic             any_press;
    logic             multi_press;
    logic [SYM_W-1:0] sym;

    key_sync #(.N(KEYS), .STAGES(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (key_raw),
        .press (press)
    );

    press_encode #(.N(KEYS), .SYM_W(SYM_W)) enc_i (
        .press   (press),
        .any_o   (any_press),
        .multi_o (multi_press),
        .sym_o   (sym)
    );

    seq_tracker #(
        .SYM_W   (SYM_W),
        .SEQ_LEN (SEQ_LEN),
        .CNT_W   (CNT_W),
        .CODE    (CODE)
    ) trk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (any_press),
        .multi    (multi_press),
        .sym      (sym),
        .progress (progress),
        .match    (unlock)
    );

    // R2: the flag and a full count always agree
    p_unlock_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unlock == (progress == CNT_W'(SEQ_LEN)));
endmodule

// File: tb/code_lock_top_tb_top.sv
module code_lock_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] key_raw;
    logic       unlock;
    logic [3:0] progress;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    code_lock_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_raw  (key_raw),
        .unlock   (unlock),
        .progress (progress)
    );

    // {key, expected progress, expected unlock}
    localparam int NV = 25;
    localparam logic [6:0] VEC [NV] = '{
        {2'd1, 4'd1, 1'b0}, {2'd2, 4'd2, 1'b0}, {2'd3, 4'd3, 1'b0},
        {2'd0, 4'd4, 1'b0}, {2'd0, 4'd5, 1'b0}, {2'd3, 4'd6, 1'b0},
        {2'd2, 4'd7, 1'b0}, {2'd1, 4'd8, 1'b1},
        {2'd2, 4'd0, 1'b0},
        {2'd1, 4'd1, 1'b0}, {2'd2, 4'd2, 1'b0}, {2'd1, 4'd1, 1'b0},
        {2'd2, 4'd2, 1'b0}, {2'd3, 4'd3, 1'b0}, {2'd3, 4'd0, 1'b0},
        {2'd1, 4'd1, 1'b0}, {2'd2, 4'd2, 1'b0}, {2'd3, 4'd3, 1'b0},
        {2'd0, 4'd4, 1'b0}, {2'd0, 4'd5, 1'b0}, {2'd3, 4'd6, 1'b0},
        {2'd2, 4'd7, 1'b0}, {2'd1, 4'd8, 1'b1},
        {2'd1, 4'd1, 1'b0}, {2'd0, 4'd0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic press_key(input int k, input int hold);
        key_raw[k] = 1'b1;
        repeat (hold) @(negedge clk);
        key_raw[k] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic enter_code();
        press_key(1, 4); press_key(2, 4); press_key(3, 4); press_key(0, 4);
        press_key(0, 4); press_key(3, 4); press_key(2, 4); press_key(1, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        key_raw = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset progress", progress, 0);
        chk("R1 reset unlock", unlock, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", progress, 0);

        // table walk: R2 full code, R4 repeated 0, R6 wrong keys, R8 restart
        for (int v = 0; v < NV; v++) begin
            press_key(int'(VEC[v][6:5]), 4);
            chk("R2/R6/R8 progress", progress, int'(VEC[v][4:1]));
            chk("R2/R8 unlock", unlock, int'(VEC[v][0]));
        end

        // R3 latency: visible on the third rising edge
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        key_raw[1] = 1'b1;
        @(negedge clk);
        chk("R3 edge1", progress, 0);
        @(negedge clk);
        chk("R3 edge2", progress, 0);
        @(negedge clk);
        chk("R3 edge3", progress, 1);
        // R4 long hold gives one event
        repeat (20) @(negedge clk);
        chk("R4 held key", progress, 1);
        // R5 release changes nothing
        key_raw[1] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 release", progress, 1);
        chk("R5 release unlock", unlock, 0);
        // R6 wrong key 1 while expecting 2
        press_key(1, 4);
        chk("R6 wrong one", progress, 1);
        press_key(2, 4);
        press_key(3, 4);
        chk("R3 step", progress, 3);
        // R7 two keys in one cycle
        key_raw = 4'b0011;
        repeat (4) @(negedge clk);
        key_raw = '0;
        repeat (4) @(negedge clk);
        chk("R7 multi press", progress, 0);
        // R7 from near the end, including key 1
        press_key(1, 4); press_key(2, 4); press_key(3, 4); press_key(0, 4);
        press_key(0, 4); press_key(3, 4); press_key(2, 4);
        chk("R3 seven", progress, 7);
        key_raw = 4'b0110;
        repeat (4) @(negedge clk);
        key_raw = '0;
        repeat (4) @(negedge clk);
        chk("R7 multi late", progress, 0);
        chk("R7 multi unlock", unlock, 0);

        // R8 unlock holds while idle, then R1 reset clears it
        enter_code();
        repeat (30) @(negedge clk);
        chk("R8 unlock held", unlock, 1);
        chk("R8 progress held", progress, 8);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears unlock", unlock, 0);
        chk("R1 reset clears progress", progress, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule